// File: doc/BRIEF.md
# Power-Fail Chip Enable Gate

This block sits in the path of an active-low chip enable. The enable runs from a host to a battery-backed static RAM. While the supply is good, the block passes the host enable to the memory. When an external comparator reports that the supply has failed, the block write-protects the memory by holding the conditioned enable high.

An access that is already running when the failure is seen may complete, but only up to a write-protect timeout counted in clock cycles. Once the supply returns, the enable stays blocked for a recovery period, also counted in clock cycles.

The supply-good flag passes through a parameterised synchronizer. The host enable is sampled once on the same clock, and the conditioned enable leaves the block from a register. Reset places the block in the recovery hold, as if the supply had just come back.

Top module: `pfce_gate`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `ce_out_n` is 1 (inactive).
- R2: In normal operation with the supply good, `ce_out_n` equals the value `host_ce_n` had two rising edges earlier (one sampling register, one output register).
- R3: If the failure is detected while the sampled host enable is 1 (idle), `ce_out_n` is 1 from the detecting edge on.
- R4: If the failure is detected while the sampled host enable is 0, `ce_out_n` stays 0 until the host enable returns to 1. After that, `ce_out_n` is held at 1.
- R5: An access still active WP_CYCLES edges after the detecting edge is cut off. `ce_out_n` stays 0 for exactly WP_CYCLES cycles and is then 1 even though the host enable is still 0.
- R6: After the synchronized supply flag returns to 1, `ce_out_n` is 1 for at least REC_CYCLES cycles, whatever the host enable does.
- R7: A host access that starts after the failure is detected never drives `ce_out_n` to 0 while the supply is bad.
- R8: A host access that is active when the recovery period ends is not passed on. Normal operation resumes only once the sampled host enable is 1.
- R9: A new failure during the recovery period returns the block to protection. The next recovery period counts its full REC_CYCLES from the start.
- R10: `supply_good` reaches the state machine through SYNC_STAGES registers. An access that starts together with a supply drop is passed on before the drop is seen, and it is then handled as in-flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_ce_n | input | 1 | Host chip enable, active low |
| supply_good | input | 1 | Supply within tolerance, from external comparator, 1 = good |
| ce_out_n | output | 1 | Conditioned chip enable to the memory, active low |

## Verification
A host enable change reaches `ce_out_n` two rising edges after it is driven. A supply change acts SYNC_STAGES+1 edges after it is driven: two edges through the synchronizer and one through the state register that drives the output. In the timeout case, the output rises WP_CYCLES edges after the detecting edge. The bench drives inputs on falling edges and counts those edges before every directed check. A behavioural reference model advances on each rising edge and uses the same pipeline delays. Its expected output is compared with `ce_out_n` on every falling edge.

// File: rtl/pfce_pkg.sv
package pfce_pkg;

    typedef enum logic [1:0] {
        ST_PASS   = 2'd0,
        ST_FINISH = 2'd1,
        ST_LOCK   = 2'd2,
        ST_COOL   = 2'd3
    } gate_state_e;

    typedef struct packed {
        logic host_idle;
        logic supply_ok;
    } gate_in_s;

    typedef struct packed {
        logic clr;
        logic inc;
    } timer_ctl_s;

    function automatic logic state_passes(gate_state_e s);
        return (s == ST_PASS) || (s == ST_FINISH);
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pfce_sync.sv
module pfce_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_chain
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain <= {STAGES{RST_VAL}};
                end else if (STAGES == 1) begin
                    chain[0] <= d;
                end else begin
                    chain <= {chain[STAGES-2:0], d};
                end
            end
            assign q = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/pfce_timer.sv
module pfce_timer
    import pfce_pkg::*;
#(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  timer_ctl_s    ctl,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || ctl.clr) begin
            cnt <= '0;
        end else if (ctl.inc) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pfce_fsm.sv
module pfce_fsm
    import pfce_pkg::*;
#(
    parameter int unsigned WP_CYCLES  = 4,
    parameter int unsigned REC_CYCLES = 8,
    parameter int unsigned CW         = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  gate_in_s      din,
    input  logic [CW-1:0] cnt,
    output timer_ctl_s    ctl,
    output gate_state_e   state,
    output logic          ce_next_n
);
    localparam logic [CW-1:0] WP_LAST  = CW'(WP_CYCLES - 1);
    localparam logic [CW-1:0] REC_LAST = CW'(REC_CYCLES - 1);

    gate_state_e nstate;

    always_comb begin
        nstate  = state;
        ctl     = '0;
        unique case (state)
            ST_PASS: begin
                if (!din.supply_ok) begin
                    ctl.clr = 1'b1;
                    nstate  = din.host_idle ? ST_LOCK : ST_FINISH;
                end
            end
            ST_FINISH: begin
                if (din.host_idle || (cnt >= WP_LAST)) begin
                    nstate = ST_LOCK;
                end else begin
                    ctl.inc = 1'b1;
                end
            end
            ST_LOCK: begin
                if (din.supply_ok) begin
                    ctl.clr = 1'b1;
                    nstate  = ST_COOL;
                end
            end
            ST_COOL: begin
                if (!din.supply_ok) begin
                    nstate = ST_LOCK;
                end else if (cnt >= REC_LAST) begin
                    if (din.host_idle) begin
                        nstate = ST_PASS;
                    end
                end else begin
                    ctl.inc = 1'b1;
                end
            end
            default: nstate = ST_LOCK;
        endcase
    end

    always_comb begin
        ce_next_n = state_passes(nstate) ? din.host_idle : 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_COOL;
        end else begin
            state <= nstate;
        end
    end
endmodule

// File: rtl/pfce_gate.sv
module pfce_gate
    import pfce_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned WP_CYCLES   = 1000,
    parameter int unsigned REC_CYCLES  = 40_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic host_ce_n,
    input  logic supply_good,
    output logic ce_out_n
);
    localparam int unsigned CW = $clog2(max_u(WP_CYCLES, REC_CYCLES) + 1);

    logic          pg_s;
    logic          host_q;
    logic [CW-1:0] cnt;
    timer_ctl_s    tctl;
    gate_state_e   state_q;
    gate_in_s      din;
    logic          ce_next_n;

    pfce_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pg_sync (
        .clk(clk), .rst(rst), .d(supply_good), .q(pg_s)
    );

    pfce_sync #(.STAGES(1), .RST_VAL(1'b1)) u_host_smp (
        .clk(clk), .rst(rst), .d(host_ce_n), .q(host_q)
    );

    assign din.host_idle = host_q;
    assign din.supply_ok = pg_s;

    pfce_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst(rst), .ctl(tctl), .cnt(cnt)
    );

    pfce_fsm #(.WP_CYCLES(WP_CYCLES), .REC_CYCLES(REC_CYCLES), .CW(CW)) u_fsm (
        .clk(clk), .rst(rst), .din(din), .cnt(cnt),
        .ctl(tctl), .state(state_q), .ce_next_n(ce_next_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ce_out_n <= 1'b1;
        end else begin
            ce_out_n <= ce_next_n;
        end
    end
endmodule

// File: rtl/pfce_checker.sv
module pfce_checker
    import pfce_pkg::*;
#(
    parameter int unsigned WP  = 4,
    parameter int unsigned CW  = 8
) (
    input logic          clk,
    input logic          rst,
    input gate_state_e   state,
    input logic          supply_ok,
    input logic          host_idle,
    input logic [CW-1:0] cnt,
    input logic          ce_out_n
);
    localparam logic [CW-1:0] WP_LAST = CW'(WP - 1);

    a_r1_out_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> ce_out_n);

    a_r2_follows_host: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PASS && supply_ok) |=> (ce_out_n == $past(host_idle)));

    a_r3_idle_fail_blocks: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PASS && !supply_ok && host_idle) |=> ce_out_n);

    a_r4_inflight_kept: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FINISH && !host_idle && cnt < WP_LAST) |=> !ce_out_n);

    a_r5_timeout_bound: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FINISH) |-> (cnt <= WP_LAST));

    a_r6_recovery_blocks: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COOL) |-> ce_out_n);

    a_r7_protect_blocks: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOCK) |-> ce_out_n);
endmodule

bind pfce_gate pfce_checker #(.WP(WP_CYCLES), .CW(CW)) u_pfce_checker (
    .clk(clk), .rst(rst), .state(state_q), .supply_ok(pg_s),
    .host_idle(host_q), .cnt(cnt), .ce_out_n(ce_out_n)
);

// File: tb/test_pfce_gate.sv
module test_pfce_gate;
    localparam int S   = 2;
    localparam int WP  = 5;
    localparam int REC = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_ce_n = 1'b1;
    logic supply_good = 1'b0;
    logic ce_out_n;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    pfce_gate #(.SYNC_STAGES(S), .WP_CYCLES(WP), .REC_CYCLES(REC)) i_pfce_gate (
        .clk(clk), .rst(rst), .host_ce_n(host_ce_n),
        .supply_good(supply_good), .ce_out_n(ce_out_n)
    );

    // Behavioural reference model: 0 run, 1 finishing, 2 locked, 3 cooling
    int   m_mode = 3;
    int   m_cnt  = 0;
    bit   m_h    = 1'b1;
    bit   m_pipe [S];
    bit   m_exp  = 1'b1;

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 3; m_cnt = 0; m_h = 1'b1; m_exp = 1'b1;
            for (int i = 0; i < S; i++) m_pipe[i] = 1'b0;
        end else begin
            bit pg;
            pg = m_pipe[S-1];
            case (m_mode)
                0: if (!pg) begin m_cnt = 0; m_mode = m_h ? 2 : 1; end
                1: if (m_h || m_cnt == WP - 1) m_mode = 2; else m_cnt++;
                2: if (pg) begin m_mode = 3; m_cnt = 0; end
                default: begin
                    if (!pg) m_mode = 2;
                    else if (m_cnt >= REC - 1) begin
                        if (m_h) m_mode = 0;
                    end else m_cnt++;
                end
            endcase
            m_exp = (m_mode <= 1) ? m_h : 1'b1;
            for (int i = S - 1; i > 0; i--) m_pipe[i] = m_pipe[i-1];
            m_pipe[0] = supply_good;
            m_h = host_ce_n;
        end
    end

    always @(negedge clk) begin
        cycles++;
        checks++;
        if (ce_out_n !== m_exp) begin
            errors++;
            $display("FAIL %s model compare at cycle %0d: actual %b expected %b",
                     cur_req, cycles, ce_out_n, m_exp);
        end
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic exp);
        checks++;
        if (ce_out_n !== exp) begin
            errors++;
            $display("FAIL %s directed: actual %b expected %b", req, ce_out_n, exp);
        end
    endtask

    initial begin
        // R1: reset holds output inactive
        step(4);
        check("R1", 1'b1);
        rst = 1'b0; supply_good = 1'b1;
        step(1);
        check("R1", 1'b1);
        // R6: still recovering shortly before the period ends
        cur_req = "R6";
        step(S + REC - 2);
        check("R6", 1'b1);
        step(8);

        // R2: follow host enable in normal operation
        cur_req = "R2";
        host_ce_n = 1'b0; step(2); check("R2", 1'b0);
        host_ce_n = 1'b1; step(2); check("R2", 1'b1);
        host_ce_n = 1'b0; step(1); host_ce_n = 1'b1; step(1); check("R2", 1'b0);
        step(1); check("R2", 1'b1);

        // R3 / R7: fail while idle, later access blocked
        cur_req = "R3";
        supply_good = 1'b0; step(S + 1); check("R3", 1'b1);
        cur_req = "R7";
        host_ce_n = 1'b0; step(4); check("R7", 1'b0 ^ 1'b1);
        // R8: access held across recovery end is not passed
        cur_req = "R8";
        supply_good = 1'b1; step(S + 1 + REC + 5); check("R8", 1'b1);
        host_ce_n = 1'b1; step(3);
        host_ce_n = 1'b0; step(2); check("R8", 1'b0);
        host_ce_n = 1'b1; step(2);

        // R4: in-flight access finishes, then protected
        cur_req = "R4";
        host_ce_n = 1'b0; step(2);
        supply_good = 1'b0; step(S + 1); check("R4", 1'b0);
        host_ce_n = 1'b1; step(2); check("R4", 1'b1);
        cur_req = "R7";
        host_ce_n = 1'b0; step(3); check("R7", 1'b1);
        host_ce_n = 1'b1;
        supply_good = 1'b1; step(S + REC + 6);

        // R5: timeout cuts off a stuck access
        cur_req = "R5";
        host_ce_n = 1'b0; step(2);
        supply_good = 1'b0; step(S + WP); check("R5", 1'b0);
        step(1); check("R5", 1'b1);
        step(3); check("R5", 1'b1);
        host_ce_n = 1'b1;

        // R9: failure during recovery restarts the count
        cur_req = "R9";
        supply_good = 1'b1; step(S + 4);
        supply_good = 1'b0; step(S + 2);
        supply_good = 1'b1; step(S + 3);
        host_ce_n = 1'b0; step(2); check("R9", 1'b1);
        step(REC); check("R9", 1'b1);
        host_ce_n = 1'b1; step(4);
        host_ce_n = 1'b0; step(2); check("R9", 1'b0);
        host_ce_n = 1'b1; step(3);

        // R10: access starting with the drop passes before detection
        cur_req = "R10";
        supply_good = 1'b0; host_ce_n = 1'b0; step(2); check("R10", 1'b0);
        step(2); check("R10", 1'b0);
        host_ce_n = 1'b1; step(2); check("R10", 1'b1);
        supply_good = 1'b1; step(S + REC + 4);
        check("R10", 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule